// File: doc/BRIEF.md
# Entropy Sampling Collector

The block gathers a run of random bits from a single-bit entropy input and makes them readable as 32-bit data words on a small memory-mapped register bus. Software programs a decimation period and chooses a run length of 64, 128, 192 or 256 bits. It also picks one of four speed settings for the external source and sets the enable bit. It then sets the start bit. The block captures the entropy input once per period and places each captured bit into the data words. When the run is complete it drops the start bit. Software polls the control register until start reads back 0 and then reads the words.

Control writes carry a per-bit mask in the upper half-word. Only the control bits whose mask bit is set take the new value, so one field can be changed without a read-modify-write. A sequencer with two states, `ST_IDLE` and `ST_COLLECT`, paces the sampling. Four transitions connect them. **arm** goes from `ST_IDLE` to `ST_COLLECT` on a start request while the block is enabled. **finish** goes from `ST_COLLECT` to `ST_IDLE` on the last capture of the run. **abort** goes from `ST_COLLECT` to `ST_IDLE` when enable is cleared or a soft reset is written. **hold** keeps either state otherwise. The start bit that software reads back is the `ST_COLLECT` state itself.

Top module: `entropy_collector`

## Requirements
- R1: A write to the control register (offset 0x400) applies bits 15:0 only where the matching bit in 31:16 is 1. Every other control bit keeps its value, and the speed output changes only on a control write or a soft reset.
- R2: Control bit 1 is ENABLE and bit 0 is START. ENABLE drives `src_en` and bits 3:2 drive `src_speed`. Writing START while ENABLE is (or becomes) 0 has no effect, and START then reads 0.
- R3: Control bits 5:4 choose the run length: code 0 gives 64 bits, 1 gives 128, 2 gives 192 and 3 gives 256. The bit counter never reaches the chosen length.
- R4: The period register (offset 0x404) sets the number of clock cycles between captures. Capture k of a run (counting from 1) samples `noise_in` in the k·P-th cycle after the start write. A period of 0 behaves as 1.
- R5: Captured bits fill data word 0 from bit 0 upward and then continue into the following words. The words are readable at 0x410 + 4·i for i = 0..7. The bit position advances by at most one per cycle.
- R6: START reads 1 for exactly N·P cycles after the start write, where N is the run length and P the effective period, and then returns to 0 by itself. A start write during a run is ignored.
- R7: Clearing ENABLE during a run ends it at once: START reads 0 and no further bits are captured. A write of all zeros under a full mask stops the block.
- R8: Data words are never touched outside a capture or a soft reset. Words beyond the chosen length keep their earlier contents, and words read during a run show the partly filled value.
- R9: Reads of unmapped offsets return 0. Control bits 15:6 are not stored and read back as 0.
- R10: Writing 1 to bit 0 of the reset-control register (offset 0x004) clears the control, period and data registers and ends any run. That register reads back 0.
- R11: After reset every register reads 0, and `src_en` and `src_speed` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (12) | Register byte offset, used for reads and writes |
| bus_wen | input | 1 | Single-cycle write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, a combinational function of `bus_addr` |
| noise_in | input | 1 | Entropy source bit |
| src_en | output | 1 | Enable to the entropy source |
| src_speed | output | 2 | Speed setting to the entropy source |

## Verification
The properties assume that software leaves the period register and the length field alone while a run is in progress. The stimulus changes them only while START reads 0, and it holds every write strobe for exactly one cycle. `noise_in` is assumed to change only away from the rising edge. The bench drives it from a shift-register sequence that moves just after each falling edge, so the capture timing in R4 can be checked bit for bit against the reference model. Runs are stopped only through the normal control write or through the reset-control register, never by toggling `rst_n` mid-run.

// File: rtl/ecc_pkg.sv
package ecc_pkg;

    localparam int BUS_W = 32;

    // register byte offsets
    localparam int OFS_SRST   = 'h004;
    localparam int OFS_CTL    = 'h400;
    localparam int OFS_PERIOD = 'h404;
    localparam int OFS_DOUT   = 'h410;

    // control field positions
    localparam int CTL_START  = 0;
    localparam int CTL_EN     = 1;
    localparam int CTL_SPD_LO = 2;
    localparam int CTL_LEN_LO = 4;
    localparam int MASK_LO    = 16;
    localparam int CTL_USED   = 6;
    localparam int SRST_BIT   = 0;

    typedef enum logic [0:0] {
        ST_IDLE    = 1'b0,
        ST_COLLECT = 1'b1
    } ecc_state_e;

endpackage

// File: rtl/ecc_ctl_reg.sv
module ecc_ctl_reg
    import ecc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_ctl,
    input  logic             soft_clr,
    input  logic [BUS_W-1:0] wdata,
    output logic             en_q,
    output logic [1:0]       speed_q,
    output logic [1:0]       len_q,
    output logic             en_next,
    output logic             start_req
);

    logic [15:0] mask;
    logic [15:0] val;
    logic        en_d;
    logic [1:0]  spd_d;
    logic [1:0]  len_d;
    logic        unused_hi;

    assign mask      = wdata[MASK_LO +: 16];
    assign val       = wdata[15:0];
    assign unused_hi = ^{mask[15:CTL_USED], val[15:CTL_USED]};

    always_comb begin
        en_d  = en_q;
        spd_d = speed_q;
        len_d = len_q;
        if (wr_ctl) begin
            if (mask[CTL_EN]) begin
                en_d = val[CTL_EN];
            end
            for (int b = 0; b < 2; b++) begin
                if (mask[CTL_SPD_LO + b]) begin
                    spd_d[b] = val[CTL_SPD_LO + b];
                end
                if (mask[CTL_LEN_LO + b]) begin
                    len_d[b] = val[CTL_LEN_LO + b];
                end
            end
        end
        if (soft_clr) begin
            en_d  = 1'b0;
            spd_d = '0;
            len_d = '0;
        end
    end

    assign en_next   = en_d;
    assign start_req = wr_ctl && mask[CTL_START] && val[CTL_START] && en_d && !soft_clr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            speed_q <= '0;
            len_q   <= '0;
        end else begin
            en_q    <= en_d;
            speed_q <= spd_d;
            len_q   <= len_d;
        end
    end

endmodule

// File: rtl/ecc_seq_fsm.sv
module ecc_seq_fsm
    import ecc_pkg::*;
#(
    parameter int PERIOD_W  = 32,
    parameter int BIT_IDX_W = 8,
    parameter int LEN_UNIT  = 64
)(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_req,
    input  logic                 stop_req,
    input  logic [PERIOD_W-1:0]  period,
    input  logic [1:0]           len_code,
    output logic                 busy,
    output logic                 cap_stb,
    output logic [BIT_IDX_W-1:0] cap_idx
);

    ecc_state_e           state_q;
    ecc_state_e           state_d;
    logic [PERIOD_W-1:0]  pcnt_q;
    logic [BIT_IDX_W-1:0] bcnt_q;
    logic [PERIOD_W-1:0]  eff_m1;
    logic [BIT_IDX_W-1:0] last_idx;
    logic                 tick;
    logic                 last_bit;

    assign eff_m1   = (period == '0) ? '0 : period - 1'b1;
    assign last_idx = BIT_IDX_W'((int'(len_code) + 1) * LEN_UNIT - 1);
    assign tick     = (pcnt_q >= eff_m1);
    assign last_bit = (bcnt_q == last_idx);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: arm, finish, abort, hold
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_req) begin
                    state_d = ST_COLLECT;
                end
            end
            ST_COLLECT: begin
                if (stop_req) begin
                    state_d = ST_IDLE;
                end else if (tick && last_bit) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy    = 1'b0;
        cap_stb = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                busy = 1'b0;
            end
            ST_COLLECT: begin
                busy    = 1'b1;
                cap_stb = tick && !stop_req;
            end
            default: begin
                busy = 1'b0;
            end
        endcase
    end

    assign cap_idx = bcnt_q;

    // period and bit counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pcnt_q <= '0;
            bcnt_q <= '0;
        end else if (state_q == ST_IDLE) begin
            if (start_req) begin
                pcnt_q <= '0;
                bcnt_q <= '0;
            end
        end else if (!stop_req) begin
            if (tick) begin
                pcnt_q <= '0;
                bcnt_q <= bcnt_q + 1'b1;
            end else begin
                pcnt_q <= pcnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/ecc_data_bank.sv
module ecc_data_bank #(
    parameter int WORD_W    = 32,
    parameter int MAX_WORDS = 8,
    parameter int BIT_IDX_W = 8
)(
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 soft_clr,
    input  logic                                 cap_stb,
    input  logic [BIT_IDX_W-1:0]                 cap_idx,
    input  logic                                 cap_bit,
    output logic [MAX_WORDS-1:0][WORD_W-1:0]     words_o
);

    localparam int POS_W = $clog2(WORD_W);
    localparam int SEL_W = BIT_IDX_W - POS_W;

    logic [SEL_W-1:0] sel;
    logic [POS_W-1:0] pos;

    assign sel = cap_idx[BIT_IDX_W-1:POS_W];
    assign pos = cap_idx[POS_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            words_o <= '0;
        end else if (soft_clr) begin
            words_o <= '0;
        end else if (cap_stb) begin
            for (int w = 0; w < MAX_WORDS; w++) begin
                if (sel == SEL_W'(w)) begin
                    words_o[w][pos] <= cap_bit;
                end
            end
        end
    end

endmodule

// File: rtl/entropy_collector.sv
module entropy_collector
    import ecc_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int WORD_W    = 32,
    parameter int MAX_WORDS = 8,
    parameter int PERIOD_W  = 32
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wen,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              noise_in,
    output logic              src_en,
    output logic [1:0]        src_speed
);

    localparam int TOTAL_BITS = WORD_W * MAX_WORDS;
    localparam int BIT_IDX_W  = $clog2(TOTAL_BITS);
    localparam int LEN_UNIT   = TOTAL_BITS / 4;

    logic                             hit_ctl;
    logic                             hit_per;
    logic                             hit_srst;
    logic                             wr_ctl;
    logic                             soft_clr;
    logic                             en_q;
    logic [1:0]                       len_q;
    logic                             en_next;
    logic                             start_req;
    logic                             busy;
    logic                             cap_stb;
    logic [BIT_IDX_W-1:0]             cap_idx;
    logic [PERIOD_W-1:0]              period_q;
    logic [MAX_WORDS-1:0][WORD_W-1:0] words;
    logic [MAX_WORDS-1:0]             hit_word;

    assign hit_ctl  = (bus_addr == ADDR_W'(OFS_CTL));
    assign hit_per  = (bus_addr == ADDR_W'(OFS_PERIOD));
    assign hit_srst = (bus_addr == ADDR_W'(OFS_SRST));
    assign wr_ctl   = bus_wen && hit_ctl;
    assign soft_clr = bus_wen && hit_srst && bus_wdata[SRST_BIT];

    generate
        for (genvar i = 0; i < MAX_WORDS; i++) begin : g_word_hit
            assign hit_word[i] = (bus_addr == ADDR_W'(OFS_DOUT + 4 * i));
        end
    endgenerate

    ecc_ctl_reg u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_ctl    (wr_ctl),
        .soft_clr  (soft_clr),
        .wdata     (bus_wdata),
        .en_q      (en_q),
        .speed_q   (src_speed),
        .len_q     (len_q),
        .en_next   (en_next),
        .start_req (start_req)
    );

    assign src_en = en_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            period_q <= '0;
        end else if (soft_clr) begin
            period_q <= '0;
        end else if (bus_wen && hit_per) begin
            period_q <= bus_wdata[PERIOD_W-1:0];
        end
    end

    ecc_seq_fsm #(
        .PERIOD_W  (PERIOD_W),
        .BIT_IDX_W (BIT_IDX_W),
        .LEN_UNIT  (LEN_UNIT)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_req (start_req),
        .stop_req  (!en_next || soft_clr),
        .period    (period_q),
        .len_code  (len_q),
        .busy      (busy),
        .cap_stb   (cap_stb),
        .cap_idx   (cap_idx)
    );

    ecc_data_bank #(
        .WORD_W    (WORD_W),
        .MAX_WORDS (MAX_WORDS),
        .BIT_IDX_W (BIT_IDX_W)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_clr (soft_clr),
        .cap_stb  (cap_stb),
        .cap_idx  (cap_idx),
        .cap_bit  (noise_in),
        .words_o  (words)
    );

    always_comb begin
        bus_rdata = '0;
        if (hit_ctl) begin
            bus_rdata[CTL_START]         = busy;
            bus_rdata[CTL_EN]            = en_q;
            bus_rdata[CTL_SPD_LO +: 2]   = src_speed;
            bus_rdata[CTL_LEN_LO +: 2]   = len_q;
        end else if (hit_per) begin
            bus_rdata = BUS_W'(period_q);
        end else begin
            for (int i = 0; i < MAX_WORDS; i++) begin
                if (hit_word[i]) begin
                    bus_rdata = BUS_W'(words[i]);
                end
            end
        end
    end

endmodule

// File: rtl/ecc_checker.sv
module ecc_checker #(
    parameter int BIT_IDX_W = 8,
    parameter int WORD_W    = 32,
    parameter int MAX_WORDS = 8,
    parameter int LEN_UNIT  = 64
)(
    input logic                             clk,
    input logic                             rst_n,
    input logic                             busy,
    input logic                             ctl_en,
    input logic                             en_next,
    input logic                             wr_ctl,
    input logic                             soft_clr,
    input logic [1:0]                       speed,
    input logic [1:0]                       len_code,
    input logic [BIT_IDX_W-1:0]             bit_cnt,
    input logic                             cap_stb,
    input logic [MAX_WORDS-1:0][WORD_W-1:0] words
);

    logic [BIT_IDX_W:0] run_len;
    assign run_len = (BIT_IDX_W + 1)'((int'(len_code) + 1) * LEN_UNIT);

    // R2: a run is only in progress while enabled
    p_run_needs_en_r2: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> ctl_en);

    // R3: the bit position stays below the chosen run length
    p_cnt_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> ({1'b0, bit_cnt} < run_len));

    // R4: captures only happen during a run
    p_capture_in_run_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cap_stb |-> busy);

    // R5: the bit position moves only on a capture
    p_cnt_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !cap_stb) |=> (!busy || bit_cnt == $past(bit_cnt)));

    // R1: the speed setting changes only through a control write or soft reset
    p_speed_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_ctl && !soft_clr) |=> $stable(speed));

    // R7: dropping enable ends the run on the next edge
    p_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !en_next) |=> !busy);

    // R8: data words are untouched without a capture or soft reset
    p_words_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap_stb && !soft_clr) |=> $stable(words));

endmodule

bind entropy_collector ecc_checker #(
    .BIT_IDX_W (BIT_IDX_W),
    .WORD_W    (WORD_W),
    .MAX_WORDS (MAX_WORDS),
    .LEN_UNIT  (LEN_UNIT)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .ctl_en   (en_q),
    .en_next  (en_next),
    .wr_ctl   (wr_ctl),
    .soft_clr (soft_clr),
    .speed    (src_speed),
    .len_code (len_q),
    .bit_cnt  (cap_idx),
    .cap_stb  (cap_stb),
    .words    (words)
);

// File: tb/sim_entropy_collector.sv
module sim_entropy_collector;

    localparam logic [11:0] A_SRST = 12'h004;
    localparam logic [11:0] A_CTL  = 12'h400;
    localparam logic [11:0] A_PER  = 12'h404;
    localparam logic [11:0] A_DOUT = 12'h410;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = A_CTL;
    logic        bus_wen = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        noise_in;
    logic        src_en;
    logic [1:0]  src_speed;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    entropy_collector u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wen   (bus_wen),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .noise_in  (noise_in),
        .src_en    (src_en),
        .src_speed (src_speed)
    );

    // entropy stimulus: shift-register sequence, moves just after each falling edge
    logic [15:0] lfsr = 16'hACE1;
    always @(negedge clk) begin
        #1;
        lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    end
    assign noise_in = lfsr[0];

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp, input string what);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    logic        m_en;
    logic        m_busy;
    logic [1:0]  m_spd;
    logic [1:0]  m_len;
    int unsigned m_per;
    int          m_el;
    logic [31:0] m_words [8];

    always @(posedge clk or negedge rst_n) begin : mdl
        logic       was;
        logic       n_en;
        logic [1:0] n_spd;
        logic [1:0] n_len;
        int         eff;
        int         idx;
        logic       wr_c;
        if (!rst_n) begin
            m_en = 0; m_busy = 0; m_spd = 0; m_len = 0; m_per = 0; m_el = 0;
            for (int w = 0; w < 8; w++) m_words[w] = '0;
        end else if (bus_wen && bus_addr == A_SRST && bus_wdata[0]) begin
            m_en = 0; m_busy = 0; m_spd = 0; m_len = 0; m_per = 0;
            for (int w = 0; w < 8; w++) m_words[w] = '0;
        end else begin
            was   = m_busy;
            n_en  = m_en;
            n_spd = m_spd;
            n_len = m_len;
            wr_c  = bus_wen && bus_addr == A_CTL;
            if (wr_c) begin
                if (bus_wdata[17]) n_en = bus_wdata[1];
                if (bus_wdata[18]) n_spd[0] = bus_wdata[2];
                if (bus_wdata[19]) n_spd[1] = bus_wdata[3];
                if (bus_wdata[20]) n_len[0] = bus_wdata[4];
                if (bus_wdata[21]) n_len[1] = bus_wdata[5];
            end
            if (was && n_en) begin
                m_el++;
                eff = (m_per == 0) ? 1 : int'(m_per);
                if (m_el % eff == 0) begin
                    idx = m_el / eff - 1;
                    m_words[idx / 32][idx % 32] = noise_in;
                    if (idx == 64 * (int'(m_len) + 1) - 1) m_busy = 0;
                end
            end
            if (was && !n_en) m_busy = 0;
            if (!was && wr_c && bus_wdata[16] && bus_wdata[0] && n_en) begin
                m_busy = 1;
                m_el   = 0;
            end
            m_en  = n_en;
            m_spd = n_spd;
            m_len = n_len;
            if (bus_wen && bus_addr == A_PER) m_per = bus_wdata;
        end
    end

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check("R2", {30'b0, src_speed}, {30'b0, m_spd}, "speed output");
            check("R2", {31'b0, src_en}, {31'b0, m_en}, "enable output");
            if (bus_addr == A_CTL) begin
                check("R6", bus_rdata, {26'b0, m_len, m_spd, m_en, m_busy}, "control readback");
            end
        end
    end

    // ---------------- bus tasks ----------------
    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk); #1;
        bus_addr = a; bus_wdata = d; bus_wen = 1'b1;
        @(negedge clk); #1;
        bus_wen = 1'b0; bus_addr = A_CTL; bus_wdata = '0;
        #1;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] v);
        @(negedge clk); #1;
        bus_addr = a;
        #4;
        v = bus_rdata;
    endtask

    task automatic wait_done(output int cyc);
        cyc = 0;
        while (bus_rdata[0] && cyc < 5000) begin
            cyc++;
            @(negedge clk); #2;
        end
    endtask

    task automatic cmp_words(input string req);
        logic [31:0] v;
        for (int w = 0; w < 8; w++) begin
            rd(A_DOUT + 12'(4 * w), v);
            check(req, v, m_words[w], $sformatf("data word %0d", w));
        end
    endtask

    // ---------------- watchdog ----------------
    initial begin
        #(20 * 150000);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL R6 watchdog actual=running expected=finished");
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    // ---------------- sequence ----------------
    initial begin
        logic [31:0] v;
        int          cyc;

        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;

        // R11: reset state
        rd(A_CTL, v);  check("R11", v, 32'h0, "control after reset");
        rd(A_PER, v);  check("R11", v, 32'h0, "period after reset");
        rd(A_DOUT, v); check("R11", v, 32'h0, "word 0 after reset");
        check("R11", {30'b0, src_speed, src_en} , 32'h0, "source outputs after reset");

        // R4/R6: 64 bits, period 3
        wr(A_PER, 32'd3);
        rd(A_PER, v); check("R4", v, 32'd3, "period readback");
        wr(A_CTL, 32'h003F_000A);
        wr(A_CTL, 32'h0001_0001);
        wait_done(cyc);
        check("R6", cyc, 32'd192, "busy cycles 64x3");
        rd(A_CTL, v); check("R1", v, 32'h0000_000A, "fields kept by start-only mask");
        cmp_words("R5");

        // R2: start with enable low is ignored
        wr(A_CTL, 32'h003F_0030);
        wr(A_CTL, 32'h0001_0001);
        rd(A_CTL, v); check("R2", v, 32'h0000_0030, "start without enable");

        // R3/R4: 256 bits, period 0 treated as 1
        wr(A_PER, 32'd0);
        wr(A_CTL, 32'h0003_0003);
        wait_done(cyc);
        check("R4", cyc, 32'd256, "busy cycles 256x1");
        cmp_words("R5");

        // R3/R8: 64 bits, period 2; upper words keep old contents
        wr(A_PER, 32'd2);
        wr(A_CTL, 32'h0030_0000);
        wr(A_CTL, 32'h0001_0001);
        wait_done(cyc);
        check("R3", cyc, 32'd128, "busy cycles 64x2");
        cmp_words("R8");

        // R7/R8: partial read during a run, then abort
        wr(A_PER, 32'd5);
        wr(A_CTL, 32'h0030_0020);
        wr(A_CTL, 32'h0001_0001);
        repeat (50) @(negedge clk);
        rd(A_DOUT, v);          check("R8", v, m_words[0], "word 0 mid-run");
        rd(A_DOUT + 12'd4, v);  check("R8", v, m_words[1], "word 1 mid-run");
        wr(A_CTL, 32'h0002_0000);
        rd(A_CTL, v); check("R7", v, 32'h0000_0020, "abort by enable clear");
        repeat (20) @(negedge clk);
        cmp_words("R7");

        // R1/R9: single-bit mask, unmapped control bits
        wr(A_CTL, 32'h0004_FFFF);
        rd(A_CTL, v); check("R1", v, 32'h0000_0024, "only masked bit changes");
        wr(A_CTL, 32'hFFC0_FFC0);
        rd(A_CTL, v); check("R9", v, 32'h0000_0024, "bits 15:6 not stored");

        // R9: unmapped offsets
        rd(12'h000, v); check("R9", v, 32'h0, "offset 0x000");
        rd(12'h008, v); check("R9", v, 32'h0, "offset 0x008");
        rd(12'h408, v); check("R9", v, 32'h0, "offset 0x408");
        rd(12'h430, v); check("R9", v, 32'h0, "offset 0x430");
        rd(A_SRST, v);  check("R10", v, 32'h0, "reset-control readback");

        // R7: full-mask zero write stops a run
        wr(A_CTL, 32'h003F_0003);
        repeat (10) @(negedge clk);
        wr(A_CTL, 32'hFFFF_0000);
        rd(A_CTL, v); check("R7", v, 32'h0, "zero write stops block");
        cmp_words("R7");

        // R10: soft reset during a run
        wr(A_PER, 32'd4);
        wr(A_CTL, 32'h003F_0033);
        repeat (30) @(negedge clk);
        wr(A_SRST, 32'h0000_0001);
        rd(A_CTL, v);  check("R10", v, 32'h0, "control after soft reset");
        rd(A_PER, v);  check("R10", v, 32'h0, "period after soft reset");
        rd(A_DOUT, v); check("R10", v, 32'h0, "word 0 after soft reset");
        cmp_words("R10");

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule